// File: doc/BRIEF.md
# Halted-Core Instruction and Data Transfer Chains

This block is the debug path that feeds work to a halted processor core. A debug host drives TAP state strobes and serial data. Through them it loads opcodes into a 33-bit instruction chain and moves words through a 34-bit data chain. The data chain connects to a receive register that the core reads and a transmit register that the core writes.

An opcode is handed to the core only when the TAP enters Run-Test/Idle while one of the two transfer chains is selected and a transfer instruction is loaded. A scan that stops in Pause-DR only loads the chain. A completion timer stands in for real execution. It clears the instruction-complete flag when an opcode is issued and sets it again after a fixed latency. The host polls that flag through the instruction chain.

The data chain's direction follows the loaded instruction. One instruction pushes a word towards the core. The other pulls the core's pending word out. A Ready bit reports whether each transfer took effect, and words sent while the receive register is occupied are discarded.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset `tdo`, `core_issue`, `core_rx_full` and `core_tx_full` are 0. A first instruction-chain capture returns opcode 0 with the complete flag at 1.
- R2: The instruction chain is 33 bits long and shifts LSB first: opcode bits 0..31 come first, then the complete flag at position 32. It is selected by chain number 4. An update under EXTEST (IR code 5'b00000) latches the 32 opcode bits.
- R3: Entering Run-Test/Idle while the chain number is 4 or 5 and the IR code is EXTEST or INTEST (5'b01100) gives a one-cycle `core_issue` pulse, with `core_opcode` equal to the latched opcode.
- R4: Staying in Run-Test/Idle for further cycles does not issue again. Entering it with any other chain number or IR code issues nothing.
- R5: An instruction-chain scan that ends with an update but without entering Run-Test/Idle loads the opcode and issues nothing.
- R6: An issue clears the complete flag within one cycle. The flag reads 1 again CMPL_LAT cycles later.
- R7: An instruction-chain update under INTEST leaves the latched opcode unchanged.
- R8: The data chain is 34 bits long and is selected by chain number 5. Bits 0..31 carry the word, bit 32 is Ready, and bit 33 is a retry-not-needed flag that is always captured as 1.
- R9: Under EXTEST, a capture while the receive register is empty gives Ready=1 and data 0. The following update stores the word and sets `core_rx_full`. A `core_rx_rd` pulse clears `core_rx_full`.
- R10: Under EXTEST, a capture while the receive register is full gives Ready=0. The word shifted in is dropped and `core_rx_data` keeps its value.
- R11: Under INTEST, a capture takes the transmit word with Ready=1 and empties the transmit register. When the transmit register is empty, the capture returns Ready=0 and data 0.
- R12: When a core transmit write falls in the same cycle as an INTEST capture, the capture returns the previous word and the new word stays stored, with `core_tx_full` still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_sel | input | 4 | Currently selected scan chain number |
| ir_code | input | 5 | Current instruction register contents |
| tap_capture | input | 1 | TAP is in Capture-DR this cycle |
| tap_shift | input | 1 | TAP is in Shift-DR this cycle |
| tap_update | input | 1 | TAP is in Update-DR this cycle |
| tap_idle | input | 1 | TAP is in Run-Test/Idle this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected chain |
| core_issue | output | 1 | One-cycle opcode issue strobe |
| core_opcode | output | 32 | Opcode handed to the core |
| core_rx_rd | input | 1 | Core consumes the receive register |
| core_rx_data | output | 32 | Receive register contents |
| core_rx_full | output | 1 | Receive register holds an unread word |
| core_tx_wr | input | 1 | Core writes the transmit register |
| core_tx_data | input | 32 | Word written by the core |
| core_tx_full | output | 1 | Transmit register holds an unread word |

## Verification
The core's transmit write and the host's INTEST capture both act on the transmit register, and they can fall in the same clock cycle. The bench provokes this collision by raising `core_tx_wr` with a fresh word in the same cycle as `tap_capture`, with the register already full. It then judges the outcome from the shifted-out word and Ready bit, and from a second INTEST scan that must return the fresh word. Issue and completion can also meet: the scoreboard tracks every expected issue and rejects any extra pulse while Run-Test/Idle is held.

// File: rtl/dbg_xfer_pkg.sv
// Shared constants for the debug transfer chains.
// Assumes a 5-bit instruction register and 4-bit chain numbers.
package dbg_xfer_pkg;
    localparam int IRW = 5;
    localparam int CSW = 4;

    localparam logic [IRW-1:0] IR_EXTEST = 5'b00000;
    localparam logic [IRW-1:0] IR_INTEST = 5'b01100;

    localparam logic [CSW-1:0] CH_INSN = 4'd4;
    localparam logic [CSW-1:0] CH_DATA = 4'd5;

    // True for the two instructions that give the transfer chains meaning
    function automatic logic ir_is_xfer(input logic [IRW-1:0] ir);
        return (ir == IR_EXTEST) || (ir == IR_INTEST);
    endfunction
endpackage

// File: rtl/dbg_itr_chain.sv
// Instruction chain: a DW-bit opcode field followed by the complete flag.
// Shifts LSB first, so tdo is bit 0. Capture loads the latched opcode and
// the flag. An update latches the opcode only when the loaded instruction
// is EXTEST. Assumes the caller gates the strobes with chain selection.
module dbg_itr_chain #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          is_ext,
    input  logic          cap,
    input  logic          sh,
    input  logic          upd,
    input  logic          tdi,
    input  logic          cmpl,
    output logic          so,
    output logic [DW-1:0] op_q
);
    localparam int LEN = DW + 1;

    logic [LEN-1:0] sr;

    // Capture, shift or hold the chain register
    always_ff @(posedge clk) begin
        if (!rst_n)             sr <= '0;
        else if (act && cap)    sr <= {cmpl, op_q};
        else if (act && sh)     sr <= {tdi, sr[LEN-1:1]};
    end

    // Latch a new opcode on an EXTEST update
    always_ff @(posedge clk) begin
        if (!rst_n)                      op_q <= '0;
        else if (act && upd && is_ext)   op_q <= sr[DW-1:0];
    end

    assign so = sr[0];

    p_intest_keeps_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act && upd && !is_ext) |=> $stable(op_q));
endmodule

// File: rtl/dbg_issue_ctl.sv
// Issue control: detects entry into Run-Test/Idle. When entry happens
// while a transfer chain and a transfer instruction are selected, it
// sends the latched opcode to the core as a one-cycle pulse. Remaining
// in the idle state produces no further pulses.
module dbg_issue_ctl #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          ok,
    input  logic [DW-1:0] op,
    output logic          issue,
    output logic [DW-1:0] opcode
);
    logic idle_q;

    // Remember last cycle's idle state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= idle;
    end

    // Pulse the issue strobe and present the opcode on idle entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue  <= 1'b0;
            opcode <= '0;
        end else begin
            issue <= idle && !idle_q && ok;
            if (idle && !idle_q && ok) opcode <= op;
        end
    end

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);
    p_issue_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> $past(idle));
endmodule

// File: rtl/dbg_core_stub.sv
// Core stand-in: models execution only as a completion timer. An issue
// clears the complete flag. The flag is set again LAT cycles later.
// A new issue while busy restarts the timer.
module dbg_core_stub #(
    parameter int LAT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic cmpl
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    // Count down the execution latency and raise the flag at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            cmpl <= 1'b1;
        end else if (issue) begin
            cnt  <= CW'(LAT);
            cmpl <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) cmpl <= 1'b1;
        end
    end

    p_clear_on_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !cmpl);
endmodule

// File: rtl/dbg_dtr_chain.sv
// Data chain: a DW-bit word, then the Ready bit, then a retry-not-needed
// bit. Under EXTEST, words flow into the receive register. Under INTEST,
// the transmit register is captured and emptied. A core write to the
// transmit register takes priority over emptying it.
module dbg_dtr_chain #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          is_ext,
    input  logic          cap,
    input  logic          sh,
    input  logic          upd,
    input  logic          tdi,
    input  logic          rx_rd,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    output logic          so,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          tx_full
);
    localparam int LEN = DW + 2;

    logic [LEN-1:0] sr;
    logic [DW-1:0]  tx_q;
    logic           acc_q;

    // Capture, shift or hold the chain register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (act && cap)
            sr <= is_ext ? {1'b1, !rx_full, {DW{1'b0}}}
                         : {1'b1, tx_full, (tx_full ? tx_q : {DW{1'b0}})};
        else if (act && sh)
            sr <= {tdi, sr[LEN-1:1]};
    end

    // Remember whether the pending EXTEST transfer was accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                    acc_q <= 1'b0;
        else if (act && cap && is_ext) acc_q <= !rx_full;
        else if (act && upd)           acc_q <= 1'b0;
    end

    // Receive register: host writes on accepted update, core reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (act && upd && is_ext && acc_q) begin
            rx_data <= sr[DW-1:0];
            rx_full <= 1'b1;
        end else if (rx_rd) begin
            rx_full <= 1'b0;
        end
    end

    // Transmit register: core writes, INTEST capture drains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            tx_full <= 1'b0;
        end else if (tx_wr) begin
            tx_q    <= tx_wdata;
            tx_full <= 1'b1;
        end else if (act && cap && !is_ext) begin
            tx_full <= 1'b0;
        end
    end

    assign so = sr[0];

    p_retry_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cap) |=> sr[LEN-1]);
    p_full_rx_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> ($stable(rx_data) && rx_full));
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> tx_full);
endmodule

// File: rtl/dbg_xfer_chains.sv
// Top of the halted-core transfer path. Decodes chain number and
// instruction, routes the TAP strobes to the instruction and data chains,
// issues opcodes on entry into Run-Test/Idle, and muxes tdo. Assumes the
// strobes are one-hot per cycle and that chain_sel and ir_code are stable
// during a DR scan.
module dbg_xfer_chains
    import dbg_xfer_pkg::*;
#(
    parameter int DW       = 32,
    parameter int CMPL_LAT = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CSW-1:0] chain_sel,
    input  logic [IRW-1:0] ir_code,
    input  logic           tap_capture,
    input  logic           tap_shift,
    input  logic           tap_update,
    input  logic           tap_idle,
    input  logic           tdi,
    output logic           tdo,
    output logic           core_issue,
    output logic [DW-1:0]  core_opcode,
    input  logic           core_rx_rd,
    output logic [DW-1:0]  core_rx_data,
    output logic           core_rx_full,
    input  logic           core_tx_wr,
    input  logic [DW-1:0]  core_tx_data,
    output logic           core_tx_full
);
    logic          xfer_ir, is_ext, itr_act, dtr_act, issue_ok;
    logic          itr_so, dtr_so, cmpl;
    logic [DW-1:0] op_q;

    // Decode which chain the current scan addresses
    always_comb begin
        xfer_ir  = ir_is_xfer(ir_code);
        is_ext   = (ir_code == IR_EXTEST);
        itr_act  = xfer_ir && (chain_sel == CH_INSN);
        dtr_act  = xfer_ir && (chain_sel == CH_DATA);
        issue_ok = itr_act || dtr_act;
    end

    dbg_itr_chain #(.DW(DW)) u_itr (
        .clk(clk), .rst_n(rst_n), .act(itr_act), .is_ext(is_ext),
        .cap(tap_capture), .sh(tap_shift), .upd(tap_update), .tdi(tdi),
        .cmpl(cmpl), .so(itr_so), .op_q(op_q)
    );

    dbg_issue_ctl #(.DW(DW)) u_issue (
        .clk(clk), .rst_n(rst_n), .idle(tap_idle), .ok(issue_ok),
        .op(op_q), .issue(core_issue), .opcode(core_opcode)
    );

    dbg_core_stub #(.LAT(CMPL_LAT)) u_stub (
        .clk(clk), .rst_n(rst_n), .issue(core_issue), .cmpl(cmpl)
    );

    dbg_dtr_chain #(.DW(DW)) u_dtr (
        .clk(clk), .rst_n(rst_n), .act(dtr_act), .is_ext(is_ext),
        .cap(tap_capture), .sh(tap_shift), .upd(tap_update), .tdi(tdi),
        .rx_rd(core_rx_rd), .tx_wr(core_tx_wr), .tx_wdata(core_tx_data),
        .so(dtr_so), .rx_data(core_rx_data), .rx_full(core_rx_full),
        .tx_full(core_tx_full)
    );

    // Drive tdo from whichever transfer chain is addressed
    always_comb begin
        if (itr_act)      tdo = itr_so;
        else if (dtr_act) tdo = dtr_so;
        else              tdo = 1'b0;
    end
endmodule

// File: tb/test_dbg_xfer_chains.sv
module test_dbg_xfer_chains;
    localparam int CLK_P = 10;
    localparam int WD    = 20000;

    logic        clk = 0, rst_n = 0;
    logic [3:0]  chain_sel = 0;
    logic [4:0]  ir_code = 0;
    logic        tap_capture = 0, tap_shift = 0, tap_update = 0, tap_idle = 0;
    logic        tdi = 0, tdo;
    logic        core_issue;
    logic [31:0] core_opcode, core_rx_data;
    logic        core_rx_rd = 0, core_rx_full, core_tx_wr = 0, core_tx_full;
    logic [31:0] core_tx_data = 0;

    int n_tot = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    logic [33:0] d;

    localparam logic [4:0] EXT = 5'b00000, INT = 5'b01100;
    localparam logic [31:0] OPA = 32'hE1A0_0000, OPB = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    dbg_xfer_chains i_dbg_xfer_chains (.*);

    task automatic chk(input string rq, input logic [63:0] a, input logic [63:0] e);
        n_tot++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, a, e);
        end
    endtask

    // Monitor: every issue pulse must match the next expected opcode
    always @(negedge clk) begin
        if (rst_n && core_issue) begin
            n_tot++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4 unexpected issue actual=%0h expected=none", core_opcode);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (core_opcode !== e) begin
                    n_bad++;
                    $display("FAIL R3 actual=%0h expected=%0h", core_opcode, e);
                end
            end
        end
    end

    task automatic scan(input int len, input logic [33:0] din, input bit wr_cap,
                        input logic [31:0] wdat, output logic [33:0] dout);
        dout = '0;
        tap_capture = 1;
        if (wr_cap) begin core_tx_wr = 1; core_tx_data = wdat; end
        @(negedge clk);
        tap_capture = 0; core_tx_wr = 0;
        for (int i = 0; i < len; i++) begin
            tap_shift = 1; tdi = din[i]; dout[i] = tdo;
            @(negedge clk);
        end
        tap_shift = 0; tap_update = 1;
        @(negedge clk);
        tap_update = 0;
    endtask

    // Driver side: expected issues are pushed before idle entry
    task automatic run_idle(input int n, input bit expect_issue);
        if (expect_issue) exp_q.push_back(i_dbg_xfer_chains.core_opcode === 'x ? 0 : cur_op);
        tap_idle = 1;
        repeat (n) @(negedge clk);
        tap_idle = 0;
        @(negedge clk);
    endtask

    logic [31:0] cur_op = 0;

    initial begin
        repeat (WD) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tdo", tdo, 0);
        chk("R1 issue", core_issue, 0);
        chk("R1 rx_full", core_rx_full, 0);
        chk("R1 tx_full", core_tx_full, 0);
        chain_sel = 4; ir_code = INT;
        scan(33, '0, 0, 0, d);
        chk("R1 R2 opcode after reset", d[31:0], 0);
        chk("R1 R2 complete flag after reset", d[32], 1);

        // R5 load via EXTEST ending in pause: no issue
        ir_code = EXT;
        scan(33, {2'b00, OPA}, 0, 0, d);
        cur_op = OPA;
        repeat (4) @(negedge clk);
        ir_code = INT;
        scan(33, '0, 0, 0, d);
        chk("R2 R5 latched opcode", d[31:0], OPA);

        // R3 R4 enter idle and stay: exactly one issue
        run_idle(5, 1);
        // R6 flag cleared right after issue
        scan(33, '0, 0, 0, d);
        chk("R6 flag cleared", d[32], 0);
        repeat (12) @(negedge clk);
        scan(33, '0, 0, 0, d);
        chk("R6 flag set again", d[32], 1);

        // R7 INTEST update keeps opcode
        scan(33, {2'b00, OPB}, 0, 0, d);
        scan(33, '0, 0, 0, d);
        chk("R7 opcode kept under INTEST", d[31:0], OPA);

        // R4 no issue for other chain or other instruction
        chain_sel = 0; ir_code = EXT;
        run_idle(2, 0);
        chain_sel = 5; ir_code = 5'b00010;
        run_idle(2, 0);
        // R3 chain 5 with EXTEST issues
        ir_code = EXT;
        run_idle(1, 1);
        chk("R4 no stray issue pending", exp_q.size(), 0);

        // R8 R9 EXTEST into empty receive register
        scan(34, {2'b00, 32'hCAFE_0001}, 0, 0, d);
        chk("R8 retry flag", d[33], 1);
        chk("R9 ready on empty rx", d[32], 1);
        chk("R9 capture data", d[31:0], 0);
        chk("R9 rx_full", core_rx_full, 1);
        chk("R9 rx_data", core_rx_data, 32'hCAFE_0001);
        // R10 second word dropped
        scan(34, {2'b00, 32'hDEAD_0002}, 0, 0, d);
        chk("R10 ready low on full rx", d[32], 0);
        chk("R10 rx_data kept", core_rx_data, 32'hCAFE_0001);
        core_rx_rd = 1; @(negedge clk); core_rx_rd = 0;
        chk("R9 rx emptied by core read", core_rx_full, 0);

        // R11 INTEST with empty then full transmit register
        ir_code = INT;
        scan(34, '0, 0, 0, d);
        chk("R11 ready low on empty tx", d[32], 0);
        chk("R11 data zero on empty tx", d[31:0], 0);
        core_tx_wr = 1; core_tx_data = 32'hA5A5_0003; @(negedge clk); core_tx_wr = 0;
        chk("R11 tx_full after write", core_tx_full, 1);
        scan(34, '0, 0, 0, d);
        chk("R11 ready", d[32], 1);
        chk("R11 data", d[31:0], 32'hA5A5_0003);
        chk("R11 tx drained", core_tx_full, 0);

        // R12 core write in same cycle as capture
        core_tx_wr = 1; core_tx_data = 32'h0000_00B2; @(negedge clk); core_tx_wr = 0;
        scan(34, '0, 1, 32'h0000_00B3, d);
        chk("R12 old word captured", d[31:0], 32'h0000_00B2);
        chk("R12 ready", d[32], 1);
        chk("R12 new word stays", core_tx_full, 1);
        scan(34, '0, 0, 0, d);
        chk("R12 new word readable", d[31:0], 32'h0000_00B3);

        chain_sel = 0;
        repeat (3) @(negedge clk);
        chk("R3 all issues seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule